// File: doc/BRIEF.md
# Prescaled 16-bit Timer with Compare and Capture

The block is a 16-bit up-counter whose tick rate is derived from the system clock through a prescaler chosen by a 3-bit clock-select field. The counter runs freely from 0x0000 to 0xFFFF and then wraps to zero. Two compare registers are checked against the count value. When either matches, its flag is raised one timer tick later. The wrap raises an overflow flag. A synchronized rising edge on the capture pin copies the count into a capture register and raises a capture flag.

Software reaches every register through a simple single-cycle register bus. Writes take effect at the clock edge on which `busWrite` is high. Reads are combinational from `busAddr`. The address map is: 0 count (read/write), 1 compare A, 2 compare B, 3 capture (read only), 4 clock select (3 bits), 5 interrupt enable (4 bits), 6 flags (write 1 to clear). Address 7 reads as zero. The flag and enable bit positions are: bit 0 compare A, bit 1 compare B, bit 2 overflow, bit 3 capture. A single interrupt line is asserted while any flag is set together with its enable bit.

Top module: `prescaled_timer`

## Requirements
- R1: Each timer tick adds one to the count. A tick taken at 0xFFFF gives 0x0000.
- R2: Clock-select codes give these divisors: 001 → 1, 010 → 8, 011 → 64, 100 → 256, 101 → 1024. After a write that changes the clock-select value, the prescaler restarts. N clock edges later the count has advanced by floor(N / divisor).
- R3: Clock-select codes 000, 110 and 111 hold the count still.
- R4: When the count equals compare A, flag bit 0 is set on the tick that ends that count value, and not earlier.
- R5: Compare B works the same way as compare A and sets flag bit 1.
- R6: Flag bit 2 is set on the tick that wraps the count from 0xFFFF to 0x0000, and not on the tick before it.
- R7: A rising edge on `capPin` passes through a two-flop synchronizer. On the third rising clock edge after the pin rises, the count is copied into the capture register (address 3) and flag bit 3 is set. A pin held high does not capture again.
- R8: Writing to address 6 clears each flag whose data bit is 1. Data bits of 0 leave their flags as they are.
- R9: `irq` is high exactly when some flag bit is set together with the matching bit of the enable register (address 5).
- R10: A software write to the count blocks compare flags on the next timer tick.
- R11: After reset every register reads zero and `irq` is low.
- R12: Compare A, compare B, clock select and enable read back what was written. Clock select keeps 3 bits and enable keeps 4 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 3 | Register address |
| busWrite | input | 1 | Write strobe for the addressed register |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for `busAddr` |
| capPin | input | 1 | Asynchronous capture input |
| irq | output | 1 | Interrupt request |

## Verification
Every divisor code is run from a freshly restarted prescaler. The count is sampled one edge before the first increment, exactly at the first increment, and after two and a half periods, which separates an off-by-one in the prescaler limit from a wrong divisor. The stop codes are each held for many cycles. Compare A and B are approached from below and sampled on the tick before and the tick of the flag, which tells a same-tick flag apart from the required one-tick delay. The suppression case is checked by loading the count exactly at the compare value, against loading one below it. Capture is tried at two different count values with the counter stopped, and with the pin held high, which catches level-triggered capture and missing synchronizer stages.

// File: rtl/ptimer_pkg.sv
`timescale 1ns/1ps
package ptimer_pkg;

  localparam int NUM_CMP = 2;

  localparam logic [2:0] ADDR_COUNT = 3'd0;
  localparam logic [2:0] ADDR_CMPA  = 3'd1;
  localparam logic [2:0] ADDR_CMPB  = 3'd2;
  localparam logic [2:0] ADDR_CAPT  = 3'd3;
  localparam logic [2:0] ADDR_SEL   = 3'd4;
  localparam logic [2:0] ADDR_MASK  = 3'd5;
  localparam logic [2:0] ADDR_FLAGS = 3'd6;

  typedef struct packed {
    logic               tick;
    logic               cntLoad;
    logic [NUM_CMP-1:0] cmpLoad;
    logic               maskLoad;
    logic               flagClear;
    logic               capture;
  } tmrStrobe_t;

  typedef struct packed {
    logic       valid;
    logic [3:0] shift;
  } selDecode_t;

  function automatic selDecode_t decodeSel(input logic [2:0] sel);
    selDecode_t d;
    d.valid = 1'b1;
    case (sel)
      3'b001:  d.shift = 4'd0;
      3'b010:  d.shift = 4'd3;
      3'b011:  d.shift = 4'd6;
      3'b100:  d.shift = 4'd8;
      3'b101:  d.shift = 4'd10;
      default: begin d.valid = 1'b0; d.shift = 4'd0; end
    endcase
    return d;
  endfunction

endpackage

// File: rtl/ptimer_ctrl.sv
`timescale 1ns/1ps
module ptimer_ctrl
  import ptimer_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 16,
  parameter int PRE_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              capPin,
  output tmrStrobe_t        strb,
  output logic [2:0]        clkSel
);

  logic [PRE_W-1:0]     preCnt;
  logic [PRE_W-1:0]     preLimit;
  logic [SYNC_STAGES:0] capSync;
  selDecode_t           selInfo;
  logic                 selWrite;
  logic                 selChange;

  assign selWrite  = busWrite && (busAddr == ADDR_SEL);
  assign selChange = selWrite && (busWdata[2:0] != clkSel);

  always_comb begin
    selInfo  = decodeSel(clkSel);
    preLimit = PRE_W'((32'd1 << selInfo.shift) - 32'd1);
  end

  always_comb begin
    strb           = '0;
    strb.tick      = selInfo.valid && (preCnt == preLimit);
    strb.cntLoad   = busWrite && (busAddr == ADDR_COUNT);
    strb.cmpLoad   = {busWrite && (busAddr == ADDR_CMPB),
                      busWrite && (busAddr == ADDR_CMPA)};
    strb.maskLoad  = busWrite && (busAddr == ADDR_MASK);
    strb.flagClear = busWrite && (busAddr == ADDR_FLAGS);
    strb.capture   = capSync[SYNC_STAGES-1] && !capSync[SYNC_STAGES];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSel <= 3'b000;
      preCnt <= '0;
    end else begin
      if (selWrite) clkSel <= busWdata[2:0];
      if (selChange || !selInfo.valid || strb.tick) preCnt <= '0;
      else                                          preCnt <= preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) capSync <= '0;
    else       capSync <= {capSync[SYNC_STAGES-1:0], capPin};
  end

  // Prescaler restarts after every tick
  assert_prescaler_restart_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.tick |=> (preCnt == '0));

  // Capture strobe lasts one cycle per pin edge
  assert_capture_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> !strb.capture);

endmodule

// File: rtl/ptimer_datapath.sv
`timescale 1ns/1ps
module ptimer_datapath
  import ptimer_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobe_t        strb,
  input  logic [2:0]        clkSel,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irq
);

  localparam int NUM_FLAGS = NUM_CMP + 2;
  localparam int FLAG_OVF  = NUM_CMP;
  localparam int FLAG_CAP  = NUM_CMP + 1;

  logic [CNT_W-1:0]               cnt;
  logic [NUM_CMP-1:0][CNT_W-1:0]  cmpReg;
  logic [CNT_W-1:0]               capReg;
  logic [NUM_FLAGS-1:0]           mask;
  logic [NUM_FLAGS-1:0]           flags;
  logic [NUM_FLAGS-1:0]           flagSet;
  logic [NUM_FLAGS-1:0]           flagClr;
  logic [NUM_CMP-1:0]             cmpHit;
  logic                           blockCmp;
  logic                           wrap;
  selDecode_t                     selInfo;

  assign selInfo = decodeSel(clkSel);
  assign wrap    = strb.tick && !strb.cntLoad && (cnt == '1);

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    assign cmpHit[i] = strb.tick && !strb.cntLoad && !blockCmp && (cnt == cmpReg[i]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      blockCmp <= 1'b0;
    end else if (strb.cntLoad) begin
      cnt      <= busWdata[CNT_W-1:0];
      blockCmp <= 1'b1;
    end else if (strb.tick) begin
      cnt      <= cnt + 1'b1;
      blockCmp <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpReg <= '0;
    end else begin
      for (int i = 0; i < NUM_CMP; i++)
        if (strb.cmpLoad[i]) cmpReg[i] <= busWdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             capReg <= '0;
    else if (strb.capture) capReg <= cnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              mask <= '0;
    else if (strb.maskLoad) mask <= busWdata[NUM_FLAGS-1:0];
  end

  always_comb begin
    flagSet           = '0;
    flagSet[NUM_CMP-1:0] = cmpHit;
    flagSet[FLAG_OVF] = wrap;
    flagSet[FLAG_CAP] = strb.capture;
    flagClr           = strb.flagClear ? busWdata[NUM_FLAGS-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flags <= '0;
    else       flags <= (flags & ~flagClr) | flagSet;
  end

  assign irq = |(flags & mask);

  always_comb begin
    case (busAddr)
      ADDR_COUNT: busRdata = DATA_W'(cnt);
      ADDR_CMPA:  busRdata = DATA_W'(cmpReg[0]);
      ADDR_CMPB:  busRdata = DATA_W'(cmpReg[1]);
      ADDR_CAPT:  busRdata = DATA_W'(capReg);
      ADDR_SEL:   busRdata = DATA_W'(clkSel);
      ADDR_MASK:  busRdata = DATA_W'(mask);
      ADDR_FLAGS: busRdata = DATA_W'(flags);
      default:    busRdata = '0;
    endcase
  end

  // Count advances by one on each tick
  assert_tick_increment_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && !strb.cntLoad) |=> (cnt == $past(cnt) + 1'b1));

  // Stop codes hold the count
  assert_stopped_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!selInfo.valid && !strb.cntLoad) |=> $stable(cnt));

  // Compare A flag rises only after the count sat at compare A
  assert_cmpa_source_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[0]) |-> ($past(cnt) == $past(cmpReg[0])));

  // Overflow flag rises only from the top count
  assert_overflow_source_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[FLAG_OVF]) |-> ($past(cnt) == '1));

  // Capture register holds the count seen when the flag rose
  assert_capture_value_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[FLAG_CAP]) |-> (capReg == $past(cnt)));

  // A blocked tick sets no compare A flag
  assert_blocked_tick_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && blockCmp && !strb.cntLoad && !flags[0]) |=> !flags[0]);

endmodule

// File: rtl/prescaled_timer.sv
`timescale 1ns/1ps
module prescaled_timer
  import ptimer_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              capPin,
  output logic              irq
);

  tmrStrobe_t strb;
  logic [2:0] clkSel;

  ptimer_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_W(PRE_W), .SYNC_STAGES(2)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busWdata(busWdata), .capPin(capPin), .strb(strb), .clkSel(clkSel)
  );

  ptimer_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .clkSel(clkSel),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

endmodule

// File: tb/prescaled_timer_test.sv
`timescale 1ns/1ps
module prescaled_timer_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = 3'd0;
  logic        busWrite = 1'b0;
  logic [15:0] busWdata = 16'd0;
  logic [15:0] busRdata;
  logic        capPin = 1'b0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  prescaled_timer uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busWdata(busWdata), .busRdata(busRdata), .capPin(capPin), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int divOf(input int sel);
    case (sel)
      1: return 1;
      2: return 8;
      3: return 64;
      4: return 256;
      default: return 1024;
    endcase
  endfunction

  task automatic runFor(input int sel, input int n, input string tag);
    logic [15:0] v;
    wr(3'd4, 16'd0);
    wr(3'd0, 16'd0);
    wr(3'd4, 16'(sel));
    waitEdges(n);
    rd(3'd0, v);
    chk(tag, v, 32'(n / divOf(sel)));
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11: reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk("R11 reset read", v, 0);
    end
    chk("R11 reset irq", irq, 0);

    // R12: readback and field widths
    wr(3'd1, 16'hA5C3); rd(3'd1, v); chk("R12 cmpA readback", v, 16'hA5C3);
    wr(3'd2, 16'h3C5A); rd(3'd2, v); chk("R12 cmpB readback", v, 16'h3C5A);
    wr(3'd4, 16'hFFFF); rd(3'd4, v); chk("R12 sel width", v, 16'h0007);
    wr(3'd5, 16'hFFFF); rd(3'd5, v); chk("R12 mask width", v, 16'h000F);
    wr(3'd5, 16'h0000);
    wr(3'd4, 16'h0000);

    // R2: each divisor, before, at and past the first increment
    for (int s = 1; s <= 5; s++) begin
      if (divOf(s) > 1) runFor(s, divOf(s) - 1, "R2 before first tick");
      runFor(s, divOf(s), "R2 first tick");
      runFor(s, 2 * divOf(s) + divOf(s) / 2, "R2 after several ticks");
    end

    // R3: stop codes
    for (int k = 0; k < 3; k++) begin
      int code;
      code = (k == 0) ? 0 : 5 + k;
      wr(3'd4, 16'd0);
      wr(3'd0, 16'd100);
      wr(3'd4, 16'(code));
      waitEdges(50);
      rd(3'd0, v);
      chk("R3 stop code holds count", v, 100);
    end
    wr(3'd4, 16'd0);

    // R1, R6: wrap and overflow flag
    wr(3'd6, 16'h000F);
    wr(3'd0, 16'hFFFD);
    wr(3'd4, 16'd1);
    waitEdges(2);
    rd(3'd0, v); chk("R1 count reaches top", v, 16'hFFFF);
    rd(3'd6, v); chk("R6 no overflow before wrap", v[2], 0);
    waitEdges(1);
    rd(3'd0, v); chk("R1 wrap to zero", v, 0);
    rd(3'd6, v); chk("R6 overflow on wrap", v[2], 1);
    wr(3'd4, 16'd0);

    // R4, R5: compare flags one tick after match
    wr(3'd1, 16'd10);
    wr(3'd2, 16'd20);
    wr(3'd0, 16'd5);
    wr(3'd6, 16'h000F);
    wr(3'd4, 16'd1);
    waitEdges(5);
    rd(3'd0, v); chk("R4 count at compare A", v, 10);
    rd(3'd6, v); chk("R4 flag not yet set", v[0], 0);
    waitEdges(1);
    rd(3'd6, v); chk("R4 flag set next tick", v[0], 1);
    waitEdges(9);
    rd(3'd6, v); chk("R5 flag not yet set", v[1], 0);
    waitEdges(1);
    rd(3'd6, v); chk("R5 flag set next tick", v[1], 1);
    wr(3'd4, 16'd0);

    // R9: interrupt masking
    rd(3'd6, v); chk("R9 flags A,B only", v, 16'h0003);
    chk("R9 irq low with mask zero", irq, 0);
    wr(3'd5, 16'h0004); #1; chk("R9 irq low, unset flag enabled", irq, 0);
    wr(3'd5, 16'h0001); #1; chk("R9 irq high, flag A enabled", irq, 1);

    // R8: write one to clear
    wr(3'd6, 16'h0000); rd(3'd6, v); chk("R8 zero write keeps flags", v, 16'h0003);
    wr(3'd6, 16'h0001); rd(3'd6, v); chk("R8 clear bit 0 only", v, 16'h0002);
    #1; chk("R9 irq drops after clear", irq, 0);
    wr(3'd5, 16'h0002); #1; chk("R9 irq high, flag B enabled", irq, 1);
    wr(3'd6, 16'h0002); #1; chk("R8 R9 all cleared irq low", irq, 0);
    wr(3'd5, 16'h0000);

    // R10: counter write blocks next tick's compare
    wr(3'd1, 16'd30);
    wr(3'd0, 16'd30);
    wr(3'd6, 16'h000F);
    wr(3'd4, 16'd1);
    waitEdges(1);
    rd(3'd0, v); chk("R10 count moved on", v, 31);
    rd(3'd6, v); chk("R10 compare blocked after write", v[0], 0);
    wr(3'd4, 16'd0);
    wr(3'd0, 16'd29);
    wr(3'd6, 16'h000F);
    wr(3'd4, 16'd1);
    waitEdges(2);
    rd(3'd6, v); chk("R10 compare fires one tick later", v[0], 1);
    wr(3'd4, 16'd0);

    // R7: capture through synchronizer
    wr(3'd0, 16'h1234);
    wr(3'd6, 16'h000F);
    capPin = 1'b1;
    waitEdges(2);
    rd(3'd6, v); chk("R7 no capture after two edges", v[3], 0);
    waitEdges(1);
    rd(3'd6, v); chk("R7 capture flag third edge", v[3], 1);
    rd(3'd3, v); chk("R7 captured count", v, 16'h1234);
    wr(3'd6, 16'h0008);
    waitEdges(5);
    rd(3'd6, v); chk("R7 held pin no recapture", v[3], 0);
    capPin = 1'b0;
    wr(3'd0, 16'h55AA);
    waitEdges(4);
    capPin = 1'b1;
    waitEdges(3);
    rd(3'd3, v); chk("R7 second capture value", v, 16'h55AA);
    rd(3'd6, v); chk("R7 second capture flag", v[3], 1);
    capPin = 1'b0;

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog run did not finish actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule